// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is a single channel of a 16-bit timer. It does not own a counter. It watches a shared count value, a count-direction bit and an overflow strobe that an outside counter supplies. Three selectors decide what the channel does: a 2-bit mode field, a 2-bit edge/level field and a global center-aligned flag. The channel can timestamp edges on its input pin, drive its output pin when the count reaches a programmed value, or produce edge-aligned or center-aligned pulse-width modulation. The same 2-bit edge/level field has a different meaning in each mode. It picks the capture edge, the compare pin action, or the PWM polarity.

The 16-bit channel value is read and written one byte at a time over an 8-bit path. Byte reads of a captured value stay coherent. The first byte read freezes a copy of the whole value, and the second byte read comes from that copy. A control-register write strobe releases the copy. The same strobe, together with a clear bit, also clears the event flag.

Top module: `tmr_chan`

## Requirements
- R1: When the edge/level field is 00, pin_oe is 0 in every mode. In input-capture mode pin_oe is also 0. In compare and PWM modes with a nonzero edge/level field, pin_oe is 1.
- R2: When center_en=0 and mode_sel=00, the channel captures. Edge/level 01 captures rising edges, 10 captures falling edges and 11 captures both. The pin passes through two synchronizer flops and an edge register. A pin change made before clock edge k loads the count present at edge k+2 into the value register, and the event flag sets on that same edge.
- R3: When center_en=0 and mode_sel=01, the channel runs output compare. On a match, edge/level 01 toggles pin_out, 10 drives it to 0 and 11 drives it to 1. With 00 the pin does not change, but the event flag still sets.
- R4: When center_en=0 and mode_sel=1x, the channel runs edge-aligned PWM. With edge/level 10, a match drives pin_out to 0 and an overflow drives it to 1. With edge/level x1, a match drives it to 1 and an overflow drives it to 0. A match takes priority over an overflow in the same cycle.
- R5: When center_en=1, the channel runs center-aligned PWM whatever mode_sel is. With edge/level 10, a match drives pin_out to 0 while counting up (cnt_down=0) and to 1 while counting down. Edge/level x1 reverses both actions.
- R6: In capture mode, a byte read (rd_en=1, rd_hi=1 for bits 15:8, rd_hi=0 for bits 7:0) made while no copy is held freezes the full value. Later reads return bytes from the frozen copy until the opposite byte is read. Re-reading the same byte keeps the copy.
- R7: A cycle with ctrl_wr=1 releases the frozen copy, so the next read returns the live value.
- R8: The value register is 0 after reset. In capture mode, byte writes are ignored. In other modes, wr_hi selects the byte that a write updates.
- R9: The event flag sets on every capture or match. It clears on a cycle with ctrl_wr=1 and ctrl_clr_evt=1, and a set in that same cycle wins.
- R10: A match happens when cnt_val equals the value register and cnt_val differs from its value in the previous cycle. A count that holds at the match value acts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_val | input | 16 | Shared counter value |
| cnt_down | input | 1 | Counter direction, 1 while counting down |
| cnt_ovf | input | 1 | Counter overflow strobe |
| center_en | input | 1 | Global center-aligned PWM select |
| mode_sel | input | 2 | Channel mode field |
| edge_sel | input | 2 | Channel edge/level field |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_clr_evt | input | 1 | Clear bit carried with ctrl_wr |
| wr_en | input | 1 | Value byte write strobe |
| wr_hi | input | 1 | Write byte select, 1 for the high byte |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Value byte read strobe |
| rd_hi | input | 1 | Read byte select, 1 for the high byte |
| rd_data | output | 8 | Read byte |
| pin_in | input | 1 | Capture input pin, asynchronous |
| pin_out | output | 1 | Channel output level |
| pin_oe | output | 1 | Output enable for the channel pin |
| evt_flag | output | 1 | Channel event flag |

## Verification
The assertions assume that the mode, edge/level and center fields change only in cycles without a capture or a match. A pin action is checked against the mode held in the cycle that caused it, so a mode change in that same cycle would break the check. They also assume that cnt_val is driven cleanly every cycle, because the match qualifier compares cnt_val with the previous cycle's count. The stimulus changes configuration only while the counter holds a non-matching value. It steps the count by one per cycle, or holds it on purpose to exercise R10. It drives pin_in only in capture sequences that leave at least four cycles for the synchronizer to settle.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [2:0] {
    CH_CAP  = 3'd0,
    CH_CMP  = 3'd1,
    CH_EPWM = 3'd2,
    CH_CPWM = 3'd3
  } chan_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } pin_act_e;

  function automatic chan_mode_e decode_mode(input logic center, input logic [1:0] msel);
    chan_mode_e m;
    if (center)             m = CH_CPWM;
    else if (msel[1])       m = CH_EPWM;
    else if (msel == 2'b01) m = CH_CMP;
    else                    m = CH_CAP;
    return m;
  endfunction

  function automatic pin_act_e invert_act(input pin_act_e a);
    pin_act_e r;
    case (a)
      ACT_CLEAR: r = ACT_SET;
      ACT_SET:   r = ACT_CLEAR;
      default:   r = a;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_chan_edge.sv
module tmr_chan_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic rise_en,
  input  logic fall_en,
  output logic edge_hit
);

  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;
  logic             sync_lvl;
  logic             prev_lvl;

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_lvl = chain_q[CHAIN-2];
  assign prev_lvl = chain_q[CHAIN-1];
  assign edge_hit = (rise_en & sync_lvl & ~prev_lvl) |
                    (fall_en & ~sync_lvl & prev_lvl);

endmodule

// File: rtl/tmr_chan_valreg.sv
module tmr_chan_valreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_mode,
  input  logic         cap_hit,
  input  logic [W-1:0] cnt_val,
  input  logic         wr_en,
  input  logic         wr_hi,
  input  logic [W/2-1:0] wr_data,
  input  logic         rd_en,
  input  logic         rd_hi,
  input  logic         ctrl_wr,
  output logic [W/2-1:0] rd_data,
  output logic [W-1:0] val,
  output logic         latched,
  output logic [W-1:0] buf_val
);

  localparam int unsigned BW = W / 2;

  logic [W-1:0] val_q, val_d;
  logic         val_en;
  logic [W-1:0] buf_q;
  logic         buf_ld;
  logic         lat_q, lat_d;
  logic         first_q;
  logic [W-1:0] rd_src;

  // value register next state
  always_comb begin
    val_d  = val_q;
    val_en = 1'b0;
    if (cap_mode) begin
      if (cap_hit) begin
        val_d  = cnt_val;
        val_en = 1'b1;
      end
    end else if (wr_en) begin
      val_en = 1'b1;
      if (wr_hi) val_d[W-1:BW] = wr_data;
      else       val_d[BW-1:0] = wr_data;
    end
  end

  // read latch next state
  always_comb begin
    lat_d  = lat_q;
    buf_ld = 1'b0;
    if (!cap_mode || ctrl_wr) begin
      lat_d = 1'b0;
    end else if (rd_en) begin
      if (!lat_q) begin
        lat_d  = 1'b1;
        buf_ld = 1'b1;
      end else if (rd_hi != first_q) begin
        lat_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      first_q <= 1'b0;
    end else if (buf_ld) begin
      buf_q   <= val_q;
      first_q <= rd_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
    end
  end

  assign rd_src  = lat_q ? buf_q : val_q;
  assign rd_data = rd_hi ? rd_src[W-1:BW] : rd_src[BW-1:0];
  assign val     = val_q;
  assign latched = lat_q;
  assign buf_val = buf_q;

endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
  import tmr_chan_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  chan_mode_e   mode,
  input  logic [1:0]   els,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_down,
  input  logic         cnt_ovf,
  input  logic [W-1:0] val,
  output logic         match_evt,
  output logic         pin_q
);

  logic [W-1:0] cnt_prev_q;
  logic         hi_true;
  pin_act_e     act;
  pin_act_e     match_act;
  logic         pin_d;
  logic         pin_en;

  assign match_evt = (cnt_val == val) && (cnt_val != cnt_prev_q);
  assign hi_true   = (els == 2'b10);

  always_comb begin
    match_act = hi_true ? ACT_CLEAR : ACT_SET;
  end

  always_comb begin
    act = ACT_NONE;
    case (mode)
      CH_CMP: begin
        if (match_evt) act = pin_act_e'(els);
      end
      CH_EPWM: begin
        if (els != 2'b00) begin
          if (match_evt)    act = match_act;
          else if (cnt_ovf) act = invert_act(match_act);
        end
      end
      CH_CPWM: begin
        if (els != 2'b00 && match_evt) begin
          act = cnt_down ? invert_act(match_act) : match_act;
        end
      end
      default: act = ACT_NONE;
    endcase
  end

  always_comb begin
    pin_en = (act != ACT_NONE);
    case (act)
      ACT_TOGGLE: pin_d = ~pin_q;
      ACT_CLEAR:  pin_d = 1'b0;
      ACT_SET:    pin_d = 1'b1;
      default:    pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (pin_en) begin
      pin_q <= pin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_prev_q <= '0;
    end else begin
      cnt_prev_q <= cnt_val;
    end
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_down,
  input  logic         cnt_ovf,
  input  logic         center_en,
  input  logic [1:0]   mode_sel,
  input  logic [1:0]   edge_sel,
  input  logic         ctrl_wr,
  input  logic         ctrl_clr_evt,
  input  logic         wr_en,
  input  logic         wr_hi,
  input  logic [W/2-1:0] wr_data,
  input  logic         rd_en,
  input  logic         rd_hi,
  output logic [W/2-1:0] rd_data,
  input  logic         pin_in,
  output logic         pin_out,
  output logic         pin_oe,
  output logic         evt_flag
);

  // reset: asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[RST_STAGES-1];

  chan_mode_e   cur_mode;
  logic         cap_mode;
  logic         cap_hit;
  logic         match_evt;
  logic         set_evt;
  logic [W-1:0] chan_val;
  logic         rd_latched;
  logic [W-1:0] rd_buf;
  logic         evt_q, evt_d;

  assign cur_mode = decode_mode(center_en, mode_sel);
  assign cap_mode = (cur_mode == CH_CAP);

  tmr_chan_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_ni),
    .pin_in   (pin_in),
    .rise_en  (cap_mode & edge_sel[0]),
    .fall_en  (cap_mode & edge_sel[1]),
    .edge_hit (cap_hit)
  );

  tmr_chan_valreg #(.W(W)) u_val (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cap_mode (cap_mode),
    .cap_hit  (cap_hit),
    .cnt_val  (cnt_val),
    .wr_en    (wr_en),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_hi    (rd_hi),
    .ctrl_wr  (ctrl_wr),
    .rd_data  (rd_data),
    .val      (chan_val),
    .latched  (rd_latched),
    .buf_val  (rd_buf)
  );

  tmr_chan_out #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_ni),
    .mode      (cur_mode),
    .els       (edge_sel),
    .cnt_val   (cnt_val),
    .cnt_down  (cnt_down),
    .cnt_ovf   (cnt_ovf),
    .val       (chan_val),
    .match_evt (match_evt),
    .pin_q     (pin_out)
  );

  // event flag
  assign set_evt = cap_mode ? cap_hit : match_evt;

  always_comb begin
    evt_d = evt_q;
    if (set_evt)                    evt_d = 1'b1;
    else if (ctrl_wr && ctrl_clr_evt) evt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
    end
  end

  assign evt_flag = evt_q;
  assign pin_oe   = (edge_sel != 2'b00) && !cap_mode;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_chan_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_ni,
  input chan_mode_e   cur_mode,
  input logic [1:0]   edge_sel,
  input logic         pin_oe,
  input logic         pin_out,
  input logic         evt_flag,
  input logic         set_evt,
  input logic         ctrl_wr,
  input logic         ctrl_clr_evt,
  input logic         wr_en,
  input logic         cap_hit,
  input logic         match_evt,
  input logic         cnt_ovf,
  input logic [W-1:0] chan_val,
  input logic         rd_latched,
  input logic [W-1:0] rd_buf
);

  // R1
  off_oe_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (edge_sel == 2'b00) |-> !pin_oe);

  // R8
  cap_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cur_mode == CH_CAP && wr_en && !cap_hit) |=> $stable(chan_val));

  // R9
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    set_evt |=> evt_flag);

  // R9
  evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && ctrl_clr_evt && !set_evt) |=> !evt_flag);

  // R3
  cmp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cur_mode == CH_CMP && edge_sel == 2'b01 && match_evt) |=> (pin_out != $past(pin_out)));

  // R4
  epwm_ovf_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cur_mode == CH_EPWM && edge_sel == 2'b10 && cnt_ovf && !match_evt) |=> pin_out);

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_latched && cur_mode == CH_CAP && !ctrl_wr) |=> $stable(rd_buf));

  // R7
  latch_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_wr |=> !rd_latched);

endmodule

bind tmr_chan tmr_chan_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_ni       (rst_ni),
  .cur_mode     (cur_mode),
  .edge_sel     (edge_sel),
  .pin_oe       (pin_oe),
  .pin_out      (pin_out),
  .evt_flag     (evt_flag),
  .set_evt      (set_evt),
  .ctrl_wr      (ctrl_wr),
  .ctrl_clr_evt (ctrl_clr_evt),
  .wr_en        (wr_en),
  .cap_hit      (cap_hit),
  .match_evt    (match_evt),
  .cnt_ovf      (cnt_ovf),
  .chan_val     (chan_val),
  .rd_latched   (rd_latched),
  .rd_buf       (rd_buf)
);

// File: tb/tmr_chan_test.sv
module tmr_chan_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt_val;
  logic        cnt_down, cnt_ovf, center_en;
  logic [1:0]  mode_sel, edge_sel;
  logic        ctrl_wr, ctrl_clr_evt, wr_en, wr_hi, rd_en, rd_hi, pin_in;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic        pin_out, pin_oe, evt_flag;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_chan uut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .cnt_ovf(cnt_ovf), .center_en(center_en), .mode_sel(mode_sel),
    .edge_sel(edge_sel), .ctrl_wr(ctrl_wr), .ctrl_clr_evt(ctrl_clr_evt),
    .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data), .rd_en(rd_en),
    .rd_hi(rd_hi), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .evt_flag(evt_flag)
  );

  // {center_en, mode_sel, edge_sel, expected pin_oe}
  localparam int NVEC = 12;
  localparam logic [5:0] OE_VEC [NVEC] = '{
    6'b0_00_00_0, 6'b0_00_01_0, 6'b0_00_11_0, 6'b0_01_00_0,
    6'b0_01_01_1, 6'b0_01_10_1, 6'b0_10_10_1, 6'b0_11_01_1,
    6'b0_10_00_0, 6'b1_00_10_1, 6'b1_01_01_1, 6'b1_11_00_0
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic hi, output logic [7:0] d);
    rd_hi = hi;
    rd_en = 1'b1;
    #1;
    d = rd_data;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(1'b1, h);
    rd(1'b0, l);
    v = {h, l};
  endtask

  task automatic wr(input logic hi, input logic [7:0] d);
    wr_hi = hi;
    wr_data = d;
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic ctl(input logic clr);
    ctrl_wr = 1'b1;
    ctrl_clr_evt = clr;
    tick();
    ctrl_wr = 1'b0;
    ctrl_clr_evt = 1'b0;
  endtask

  task automatic step(input logic [15:0] c, input logic dn);
    cnt_val = c;
    cnt_down = dn;
    tick();
  endtask

  task automatic cap_run(input logic lvl, input logic [15:0] base);
    pin_in = lvl;
    for (int i = 0; i < 4; i++) begin
      cnt_val = base + 16'(i);
      tick();
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    rst_n = 1'b0; cnt_val = '0; cnt_down = 0; cnt_ovf = 0; center_en = 0;
    mode_sel = 0; edge_sel = 0; ctrl_wr = 0; ctrl_clr_evt = 0; wr_en = 0;
    wr_hi = 0; wr_data = 0; rd_en = 0; rd_hi = 0; pin_in = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) tick();

    // reset state
    check("R8 reset pin_out", {15'd0, pin_out}, 16'd0);
    check("R9 reset evt", {15'd0, evt_flag}, 16'd0);
    rd_hi = 1'b1; #1; check("R8 reset value hi", {8'd0, rd_data}, 16'd0);
    rd_hi = 1'b0; #1; check("R8 reset value lo", {8'd0, rd_data}, 16'd0);

    // R1 output-enable table
    for (int i = 0; i < NVEC; i++) begin
      {center_en, mode_sel, edge_sel} = OE_VEC[i][5:1];
      #1;
      check($sformatf("R1 oe vector %0d", i), {15'd0, pin_oe}, {15'd0, OE_VEC[i][0]});
    end
    tick();

    // output compare
    center_en = 0; mode_sel = 2'b01; edge_sel = 2'b01;
    wr(1'b1, 8'h00); wr(1'b0, 8'h05);
    rd16(v); check("R8 write in compare", v, 16'h0005);
    step(3, 0); step(4, 0); step(5, 0);
    check("R3 toggle on match", {15'd0, pin_out}, 16'd1);
    check("R9 evt on match", {15'd0, evt_flag}, 16'd1);
    step(5, 0);
    check("R10 held count no retoggle", {15'd0, pin_out}, 16'd1);
    ctl(1'b1);
    check("R9 clear by write one", {15'd0, evt_flag}, 16'd0);
    edge_sel = 2'b10; step(4, 0); step(5, 0);
    check("R3 clear on match", {15'd0, pin_out}, 16'd0);
    edge_sel = 2'b11; step(4, 0); step(5, 0);
    check("R3 set on match", {15'd0, pin_out}, 16'd1);
    ctl(1'b1);
    edge_sel = 2'b00; step(4, 0); step(5, 0);
    check("R3 software compare pin kept", {15'd0, pin_out}, 16'd1);
    check("R3 software compare evt", {15'd0, evt_flag}, 16'd1);
    check("R1 software compare oe", {15'd0, pin_oe}, 16'd0);

    // edge-aligned PWM, low-true then high-true
    mode_sel = 2'b10; edge_sel = 2'b01;
    cnt_ovf = 1; step(0, 0); cnt_ovf = 0;
    check("R4 low-true ovf clears", {15'd0, pin_out}, 16'd0);
    for (int i = 1; i <= 4; i++) step(16'(i), 0);
    check("R4 low-true before match", {15'd0, pin_out}, 16'd0);
    step(5, 0);
    check("R4 low-true match sets", {15'd0, pin_out}, 16'd1);
    edge_sel = 2'b10;
    cnt_ovf = 1; step(0, 0); cnt_ovf = 0;
    check("R4 high-true ovf sets", {15'd0, pin_out}, 16'd1);
    for (int i = 1; i <= 5; i++) step(16'(i), 0);
    check("R4 high-true match clears", {15'd0, pin_out}, 16'd0);

    // center-aligned PWM
    center_en = 1; mode_sel = 2'b00; edge_sel = 2'b10;
    step(6, 1); step(5, 1);
    check("R5 high-true down match sets", {15'd0, pin_out}, 16'd1);
    step(4, 0); step(5, 0);
    check("R5 high-true up match clears", {15'd0, pin_out}, 16'd0);
    edge_sel = 2'b01;
    step(4, 0); step(5, 0);
    check("R5 low-true up match sets", {15'd0, pin_out}, 16'd1);
    step(6, 1); step(5, 1);
    check("R5 low-true down match clears", {15'd0, pin_out}, 16'd0);
    cnt_down = 0;

    // input capture
    center_en = 0; mode_sel = 2'b00; edge_sel = 2'b01;
    ctl(1'b1);
    check("R1 capture oe", {15'd0, pin_oe}, 16'd0);
    cap_run(1'b1, 16'd100);
    check("R9 evt on capture", {15'd0, evt_flag}, 16'd1);
    rd16(v); check("R2 rising capture timing", v, 16'd102);
    ctl(1'b1);
    cap_run(1'b0, 16'd200);
    check("R2 falling ignored evt", {15'd0, evt_flag}, 16'd0);
    rd16(v); check("R2 falling ignored value", v, 16'd102);
    edge_sel = 2'b10;
    cap_run(1'b1, 16'd250);
    rd16(v); check("R2 rising ignored in falling mode", v, 16'd102);
    cap_run(1'b0, 16'd300);
    rd16(v); check("R2 falling capture", v, 16'd302);
    edge_sel = 2'b11;
    cap_run(1'b1, 16'd400);
    rd16(v); check("R2 both edges rise", v, 16'd402);
    cap_run(1'b0, 16'd500);
    rd16(v); check("R2 both edges fall", v, 16'd502);

    // writes ignored in capture
    wr(1'b1, 8'hAB); wr(1'b0, 8'hCD);
    rd16(v); check("R8 capture write ignored", v, 16'd502);

    // coherent read latch
    rd(1'b1, b); check("R6 first byte live", {8'd0, b}, 16'h0001);
    cap_run(1'b1, 16'd600);
    rd(1'b0, b); check("R6 second byte from latch", {8'd0, b}, 16'h00F6);
    rd(1'b0, b); check("R6 unlatched after pair", {8'd0, b}, 16'h005A);
    cap_run(1'b0, 16'd800);
    rd(1'b0, b); check("R6 same byte keeps latch", {8'd0, b}, 16'h005A);
    ctl(1'b0);
    rd(1'b1, b); check("R7 ctrl write releases latch", {8'd0, b}, 16'h0003);
    rd(1'b0, b); check("R7 low byte after release", {8'd0, b}, 16'h0022);

    // reset again
    rst_n = 1'b0;
    #1;
    check("R8 async reset pin", {15'd0, pin_out}, 16'd0);
    check("R9 async reset evt", {15'd0, evt_flag}, 16'd0);
    rd_hi = 1'b0; #1;
    check("R8 async reset value", {8'd0, rd_data}, 16'd0);

    summary();
    $finish;
  end

endmodule